// File: doc/BRIEF.md
# Reset Source Arbitration Controller

This block takes reset requests from six sources and drives one system reset. It sorts each request into one of two classes. An immediate request drives reset without reference to the clock. A deferred request waits until the bus transfer in progress has ended, so that a write already under way completes.

While a deferred request waits, the block forces its bus-cycle timeout monitor on. A transfer that never terminates is then cut off after a programmable number of clocks. When reset ends, a status register records the single cause of that reset. The power-on request is the active-low asynchronous reset input itself. It also returns the monitor configuration (enable and timeout) to its defaults.

Top module: `rst_arb_ctrl`

## Requirements
- R1: A high level on `lvd_req_i`, `loc_req_i` or `lol_req_i`, or on `ext_req_i` while `stop_mode_i` is high, drives `sys_rst_o` high at once, before any clock edge.
- R2: A deferred request (`sw_req_i`, or `ext_req_i` with `stop_mode_i` low) that is sampled at a rising edge while no bus cycle is open drives `sys_rst_o` high from that edge. It does not act before that edge.
- R3: A deferred request that is sampled while a bus cycle is open leaves `sys_rst_o` low while the cycle is open. The cycle opens at the edge that samples `bus_start_i` and closes at the edge that samples `bus_done_i` or an abort. `sys_rst_o` then rises on the next rising edge after the closing edge.
- R4: While a deferred request is pending, `bmon_active_o` is high even when the stored enable bit is 0. With the enable bit at 0 and nothing pending, `bmon_active_o` stays low and no abort occurs.
- R5: When the monitor is active, `bmon_abort_o` is high during the cycle in which the open bus cycle's age equals the stored timeout. The age is 0 after the opening edge and grows by one each edge. The abort closes the bus cycle at the next edge and lasts one cycle.
- R6: `rst_status_o` holds exactly one set bit. The bit positions are: power-on bit 3, external bit 2, loss of clock bit 1, loss of lock bit 0. The value is 0x08 during and after power-on reset.
- R7: A software reset is recorded as bit 5 (0x20) and a low-voltage reset as bit 6 (0x40). Bit 4 always reads 0.
- R8: `rst_status_o` changes only at the clock edge where `sys_rst_o` falls, and is otherwise held through every reset except power-on.
- R9: When requests coincide, any immediate request beats any deferred one. Among immediate requests the order is low-voltage, then loss of clock, then loss of lock, then external. Between deferred requests, external beats software.
- R10: After the last deferred request is seen low at a rising edge, `sys_rst_o` falls on the HOLD_CYCLES-th rising edge, counting that first edge. Immediate requests and power-on are seen through a SYNC_STAGES-flop synchronizer, which adds SYNC_STAGES edges. Reset never falls while any request is high.
- R11: Power-on reset sets the monitor enable to 0 and the timeout to BMT_DEFAULT. A write with `cfg_we_i` high updates both at a rising edge. Other resets keep them.
- R12: `ext_req_i` is deferred when `stop_mode_i` is low and immediate when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset request, active low, asynchronous |
| ext_req_i | input | 1 | External pin reset request |
| loc_req_i | input | 1 | Loss-of-clock reset request |
| lol_req_i | input | 1 | Loss-of-lock reset request |
| lvd_req_i | input | 1 | Low-voltage reset request |
| sw_req_i | input | 1 | Software reset request |
| stop_mode_i | input | 1 | Device in stop mode |
| bus_start_i | input | 1 | Bus cycle start strobe |
| bus_done_i | input | 1 | Bus cycle normal termination strobe |
| cfg_we_i | input | 1 | Monitor configuration write strobe |
| cfg_bme_i | input | 1 | Monitor enable value to write |
| cfg_bmt_i | input | BMT_W | Monitor timeout value to write |
| sys_rst_o | output | 1 | System reset, active high |
| bmon_active_o | output | 1 | Bus monitor effectively enabled |
| bmon_abort_o | output | 1 | Forced bus-cycle termination |
| rst_status_o | output | 7 | Cause of the last reset, one-hot |

## Verification
The bench builds the block with HOLD_CYCLES=6, BMT_W=4 and BMT_DEFAULT=9, and keeps SYNC_STAGES=2. The short stretch lets each of the many reset episodes finish in a handful of clocks. The 4-bit timeout lets the forced-abort path, the default timeout restored by power-on and the age counter be exercised within a few cycles. A timeout of 15 keeps the monitor from firing while bus termination is tested alone.

// File: rtl/rst_arb_pkg.sv
package rst_arb_pkg;

  localparam int unsigned STAT_W = 7;

  // enum value = status bit position
  typedef enum logic [2:0] {
    CZ_LOL = 3'd0,
    CZ_LOC = 3'd1,
    CZ_EXT = 3'd2,
    CZ_POR = 3'd3,
    CZ_SW  = 3'd5,
    CZ_LVD = 3'd6
  } cause_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_WAIT,
    ST_HOLD
  } arb_st_e;

  function automatic logic [STAT_W-1:0] cause_onehot(cause_e c);
    return STAT_W'(1) << c;
  endfunction

  function automatic cause_e async_pick(logic lvd, logic loc, logic lol, logic ext);
    if (lvd)      return CZ_LVD;
    else if (loc) return CZ_LOC;
    else if (lol) return CZ_LOL;
    else if (ext) return CZ_EXT;
    else          return CZ_LOC;  // request gone before capture edge
  endfunction

  function automatic cause_e sync_pick(logic ext);
    return ext ? CZ_EXT : CZ_SW;
  endfunction

endpackage

// File: rtl/rst_arb_sync.sv
module rst_arb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic set_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  // asserts asynchronously, releases through STAGES flops
  always_ff @(posedge clk_i or posedge set_i) begin
    if (set_i) ff_q <= '1;
    else       ff_q <= {ff_q[STAGES-2:0], 1'b0};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rst_arb_bmon.sv
module rst_arb_bmon #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             busy_o,
  output logic             abort_o
);
  localparam logic [CNT_W-1:0] AGE_MAX = '1;

  logic             busy_q;
  logic [CNT_W-1:0] age_q;

  assign abort_o = busy_q & active_i & (age_q >= limit_i);
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      age_q  <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      age_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        age_q  <= '0;
      end
    end else if (done_i || abort_o) begin
      busy_q <= 1'b0;
    end else if (age_q != AGE_MAX) begin
      age_q <= age_q + 1'b1;
    end
  end
endmodule

// File: rtl/rst_arb_fsm.sv
module rst_arb_fsm
  import rst_arb_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              async_s_i,
  input  cause_e            async_cause_i,
  input  logic              sync_req_i,
  input  cause_e            sync_cause_i,
  input  logic              busy_i,
  output logic              sys_rst_o,
  output logic              wait_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC - 1);

  arb_st_e           st_q;
  cause_e            cause_q;
  logic [CW-1:0]     cnt_q;
  logic [STAT_W-1:0] stat_q;
  logic              req_any;

  assign req_any   = async_s_i | sync_req_i;
  assign sys_rst_o = (st_q == ST_HOLD) | async_s_i;
  assign wait_o    = (st_q == ST_WAIT);
  assign status_o  = stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HOLD;
      cause_q <= CZ_POR;
      cnt_q   <= RELOAD;
      stat_q  <= cause_onehot(CZ_POR);
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (async_s_i) begin
            st_q    <= ST_HOLD;
            cause_q <= async_cause_i;
            cnt_q   <= RELOAD;
          end else if (sync_req_i) begin
            cause_q <= sync_cause_i;
            cnt_q   <= RELOAD;
            st_q    <= busy_i ? ST_WAIT : ST_HOLD;
          end
        end
        ST_WAIT: begin
          if (async_s_i) begin
            st_q    <= ST_HOLD;
            cause_q <= async_cause_i;
            cnt_q   <= RELOAD;
          end else if (!busy_i) begin
            st_q  <= ST_HOLD;
            cnt_q <= RELOAD;
          end
        end
        ST_HOLD: begin
          if (req_any) begin
            cnt_q <= RELOAD;
          end else if (cnt_q == '0) begin
            st_q   <= ST_RUN;
            stat_q <= cause_onehot(cause_q);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= ST_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/rst_arb_ctrl.sv
module rst_arb_ctrl
  import rst_arb_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BMT_W       = 8,
  parameter int unsigned BMT_DEFAULT = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_req_i,
  input  logic             loc_req_i,
  input  logic             lol_req_i,
  input  logic             lvd_req_i,
  input  logic             sw_req_i,
  input  logic             stop_mode_i,
  input  logic             bus_start_i,
  input  logic             bus_done_i,
  input  logic             cfg_we_i,
  input  logic             cfg_bme_i,
  input  logic [BMT_W-1:0] cfg_bmt_i,
  output logic             sys_rst_o,
  output logic             bmon_active_o,
  output logic             bmon_abort_o,
  output logic [6:0]       rst_status_o
);
  localparam logic [BMT_W-1:0] BMT_RST = BMT_W'(BMT_DEFAULT);

  logic             ext_async, ext_sync;
  logic             async_set, async_s;
  logic             sync_req;
  logic             busy, wait_st;
  logic             bme_q;
  logic [BMT_W-1:0] bmt_q;
  cause_e           async_cause, sync_cause;

  assign ext_async   = ext_req_i & stop_mode_i;
  assign ext_sync    = ext_req_i & ~stop_mode_i;
  assign async_set   = ~rst_ni | lvd_req_i | loc_req_i | lol_req_i | ext_async;
  assign sync_req    = sw_req_i | ext_sync;
  assign async_cause = async_pick(lvd_req_i, loc_req_i, lol_req_i, ext_async);
  assign sync_cause  = sync_pick(ext_sync);

  // monitor config, restored only by power-on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bme_q <= 1'b0;
      bmt_q <= BMT_RST;
    end else if (cfg_we_i) begin
      bme_q <= cfg_bme_i;
      bmt_q <= cfg_bmt_i;
    end
  end

  rst_arb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .set_i (async_set),
    .q_o   (async_s)
  );

  rst_arb_fsm #(.HOLD_CYC(HOLD_CYCLES)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .async_s_i     (async_s),
    .async_cause_i (async_cause),
    .sync_req_i    (sync_req),
    .sync_cause_i  (sync_cause),
    .busy_i        (busy),
    .sys_rst_o     (sys_rst_o),
    .wait_o        (wait_st),
    .status_o      (rst_status_o)
  );

  assign bmon_active_o = bme_q | wait_st;

  rst_arb_bmon #(.CNT_W(BMT_W)) u_bmon (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (sys_rst_o),
    .start_i  (bus_start_i),
    .done_i   (bus_done_i),
    .active_i (bmon_active_o),
    .limit_i  (bmt_q),
    .busy_o   (busy),
    .abort_o  (bmon_abort_o)
  );
endmodule

// File: rtl/rst_arb_ctrl_chk.sv
module rst_arb_ctrl_chk #(
  parameter int unsigned BMT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ext_req_i,
  input logic             loc_req_i,
  input logic             lol_req_i,
  input logic             lvd_req_i,
  input logic             sw_req_i,
  input logic             stop_mode_i,
  input logic             bus_start_i,
  input logic             bus_done_i,
  input logic             cfg_we_i,
  input logic             cfg_bme_i,
  input logic [BMT_W-1:0] cfg_bmt_i,
  input logic             sys_rst_o,
  input logic             bmon_active_o,
  input logic             bmon_abort_o,
  input logic [6:0]       rst_status_o
);
  AST_ASYNC_AT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvd_req_i | loc_req_i | lol_req_i | (ext_req_i & stop_mode_i)) |-> sys_rst_o); // R1

  AST_PENDING_FORCES_MON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && (sw_req_i || (ext_req_i && !stop_mode_i))) |=> (sys_rst_o || bmon_active_o)); // R4

  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bmon_abort_o |=> !bmon_abort_o); // R5

  AST_STATUS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rst_status_o) == 1); // R6

  AST_STATUS_BIT4_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_status_o[4]); // R7

  AST_STATUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sys_rst_o) |-> $stable(rst_status_o)); // R8

  AST_REQ_HOLDS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && (sw_req_i || ext_req_i)) |=> sys_rst_o); // R10
endmodule

bind rst_arb_ctrl rst_arb_ctrl_chk #(.BMT_W(BMT_W)) u_chk (.*);

// File: tb/rst_arb_ctrl_tb.sv
module rst_arb_ctrl_tb;
  localparam int HOLD = 6;
  localparam int STG  = 2;
  localparam int BW   = 4;
  localparam int BDEF = 9;
  localparam int N_SYNC  = HOLD - 1;        // high samples after deferred release
  localparam int N_ASYNC = HOLD + STG - 1;  // high samples after immediate release

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_req, loc_req, lol_req, lvd_req, sw_req, stop_mode;
  logic bus_start, bus_done, cfg_we, cfg_bme;
  logic [BW-1:0] cfg_bmt;
  logic sys_rst, bmon_active, bmon_abort;
  logic [6:0] status;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rst_arb_ctrl #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(STG), .BMT_W(BW), .BMT_DEFAULT(BDEF)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_req_i(ext_req), .loc_req_i(loc_req),
    .lol_req_i(lol_req), .lvd_req_i(lvd_req), .sw_req_i(sw_req), .stop_mode_i(stop_mode),
    .bus_start_i(bus_start), .bus_done_i(bus_done), .cfg_we_i(cfg_we), .cfg_bme_i(cfg_bme),
    .cfg_bmt_i(cfg_bmt), .sys_rst_o(sys_rst), .bmon_active_o(bmon_active),
    .bmon_abort_o(bmon_abort), .rst_status_o(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_status(bit lvd, bit loc, bit lol, bit ext);
    if (lvd) return 'h40;
    if (loc) return 'h02;
    if (lol) return 'h01;
    if (ext) return 'h04;
    return 0;
  endfunction

  task automatic count_hi(output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sys_rst) n++;
      else break;
    end
  endtask

  task automatic cfg(input bit bme, input int bmt);
    cfg_we = 1; cfg_bme = bme; cfg_bmt = BW'(bmt);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // deferred request during open bus cycle, normal termination
  task automatic defer_on_bus(input bit use_ext, input int exp_stat);
    int n;
    bus_start = 1;
    @(negedge clk);
    bus_start = 0;
    if (use_ext) ext_req = 1; else sw_req = 1;
    #1 chk("R3 no immediate reset", sys_rst, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 held during bus cycle", sys_rst, 0);
      chk("R4 monitor forced on", bmon_active, 1);
    end
    bus_done = 1;
    @(negedge clk);
    bus_done = 0;
    chk("R3 not on terminate edge", sys_rst, 0);
    @(negedge clk);
    chk("R3 reset next edge", sys_rst, 1);
    ext_req = 0; sw_req = 0;
    count_hi(n);
    chk("R10 deferred stretch", n, N_SYNC);
    chk(use_ext ? "R12 ext deferred cause" : "R7 sw cause", status, exp_stat);
  endtask

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    ext_req = 0; loc_req = 0; lol_req = 0; lvd_req = 0; sw_req = 0; stop_mode = 0;
    bus_start = 0; bus_done = 0; cfg_we = 0; cfg_bme = 0; cfg_bmt = '0;

    repeat (3) @(negedge clk);
    chk("R6 status in power-on", status, 'h08);
    chk("R10 reset in power-on", sys_rst, 1);
    chk("R11 enable cleared", bmon_active, 0);
    rst_ni = 1;
    count_hi(n);
    chk("R10 power-on stretch", n, N_ASYNC);
    chk("R6 status after power-on", status, 'h08);

    // R2: software reset with idle bus
    sw_req = 1;
    #1 chk("R2 not before edge", sys_rst, 0);
    @(negedge clk);
    chk("R2 reset at edge", sys_rst, 1);
    sw_req = 0;
    count_hi(n);
    chk("R10 sw stretch", n, N_SYNC);
    chk("R7 sw status", status, 'h20);

    // R4: enable 0, nothing pending -> no abort
    bus_start = 1;
    @(negedge clk);
    bus_start = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R4 monitor off", bmon_active, 0);
      chk("R4 no abort", bmon_abort, 0);
    end
    bus_done = 1;
    @(negedge clk);
    bus_done = 0;

    cfg(1'b0, 15);
    defer_on_bus(1'b0, 'h20);
    defer_on_bus(1'b1, 'h04);

    // R5: forced timeout, deferred reset proceeds
    cfg(1'b0, 3);
    bus_start = 1;
    @(negedge clk);
    bus_start = 0;
    sw_req = 1;
    for (int j = 1; j <= 5; j++) begin
      @(negedge clk);
      chk("R5 abort timing", bmon_abort, (j == 3) ? 1 : 0);
      chk("R5 reset after abort", sys_rst, (j >= 5) ? 1 : 0);
    end
    sw_req = 0;
    count_hi(n);
    chk("R7 sw after timeout", status, 'h20);

    // R5: enabled monitor on normal cycle
    cfg(1'b1, 2);
    bus_start = 1;
    @(negedge clk);
    bus_start = 0;
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      chk("R5 enabled abort", bmon_abort, (j == 2) ? 1 : 0);
      chk("R5 no reset", sys_rst, 0);
    end

    // R1 / R12: ext in stop mode is immediate
    stop_mode = 1; ext_req = 1;
    #1 chk("R12 ext in stop immediate", sys_rst, 1);
    @(negedge clk);
    ext_req = 0;
    count_hi(n);
    chk("R10 ext async stretch", n, N_ASYNC);
    chk("R6 ext status", status, 'h04);
    stop_mode = 0;

    // R1 loss of clock; R11 config kept
    loc_req = 1;
    #1 chk("R1 loc immediate", sys_rst, 1);
    @(negedge clk);
    loc_req = 0;
    count_hi(n);
    chk("R6 loc status", status, 'h02);
    chk("R11 enable kept", bmon_active, 1);

    // R11: power-on restores defaults
    rst_ni = 0;
    @(negedge clk);
    rst_ni = 1;
    count_hi(n);
    chk("R11 enable cleared", bmon_active, 0);
    chk("R6 por status", status, 'h08);
    cfg(1'b1, BDEF);
    bus_start = 1;
    @(negedge clk);
    bus_start = 0;
    for (int j = 1; j <= BDEF; j++) begin
      @(negedge clk);
      chk("R11 default timeout", bmon_abort, (j == BDEF) ? 1 : 0);
    end
    @(negedge clk);
    cfg(1'b0, 15);

    // R9: random coincident requests
    stop_mode = 1;
    for (int it = 0; it < 24; it++) begin
      int m;
      bit s;
      m = 1 + int'($urandom % 15);
      s = $urandom % 2;
      lvd_req = m[3]; loc_req = m[2]; lol_req = m[1]; ext_req = m[0]; sw_req = s;
      #1 chk("R1 immediate on mix", sys_rst, 1);
      @(negedge clk);
      lvd_req = 0; loc_req = 0; lol_req = 0; ext_req = 0; sw_req = 0;
      count_hi(n);
      chk("R10 mix stretch", n, N_ASYNC);
      chk("R9 priority", status, exp_status(m[3], m[2], m[1], m[0]));
    end
    stop_mode = 0;

    // R9: two deferred together, ext wins
    sw_req = 1; ext_req = 1;
    @(negedge clk);
    sw_req = 0; ext_req = 0;
    count_hi(n);
    chk("R9 deferred priority", status, 'h04);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule